// File: doc/BRIEF.md
# Double-to-Single Rounding Unit

This block accepts a binary64 operand, rounds it to the precision and exponent range of binary32 under one of four selectable rounding directions, and returns the rounded value re-expressed in binary64 format. The operand is taken from the low 64 bits of a 128-bit source word. The result is placed in the low 64 bits of a 128-bit result word, and the high 64 bits of that word are cleared.

Alongside the value, the unit reports status for the operation:
- signalling-NaN seen, overflow, underflow and inexact;
- whether the fraction magnitude was bumped up during rounding, and whether the result is inexact;
- a 5-bit class code, computed from the single-precision view of the result;
- a write-enable that is dropped when the invalid-operation trap is enabled and a signalling NaN arrived.

The sticky status register, decode, register-file access and trap dispatch sit elsewhere. The interface is a valid-in/valid-out pipeline with exactly one register stage.

Top module: `dsr_unit`

## Requirements
- R1: `out_valid` rises in the clock cycle after an accepted `in_valid`, with all result and status outputs registered in that same stage. Synchronous reset clears `out_valid`, `res_wr_en` and all status outputs.
- R2: Only `src_data[63:0]` is used as the operand. `res_data[127:64]` is always zero, whatever `src_data[127:64]` holds.
- R3: `rnd_mode` selects the rounding direction: 00 = nearest-even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. For a normal result, the low 29 fraction bits of `res_data[63:0]` are zero.
- R4: In nearest-even mode, an exact halfway case rounds to the neighbour whose last binary32 fraction bit is 0.
- R5: If the rounded magnitude reaches 2^128, the overflow and inexact flags are raised and `flag_fr` is 0. The result is infinity in nearest mode, in the +infinity direction for positive values and in the -infinity direction for negative values. Otherwise the result is the largest finite single magnitude (binary64 exponent field 0x47E, fraction 0xFFFFFE0000000) with the operand's sign.
- R6: An operand whose unbounded exponent is below -126 is tiny. It is aligned to the binary32 subnormal grid (step 2^-149) before rounding. Underflow is raised only when the operand is tiny and inexact; an exact tiny value raises nothing. A tiny value that rounds up to 2^-126 comes out as a normal.
- R7: A signalling NaN raises `flag_snan`. Its output is quieted by setting fraction bit 51, keeps fraction bits 50..29 and clears fraction bits 28..0. A quiet NaN passes through with the same truncation and raises no flag.
- R8: When `inv_trap_en` is 1 and the operand is a signalling NaN, `res_wr_en` is 0 and `flag_fr` and `flag_fi` are 0. In every other valid case `res_wr_en` is 1.
- R9: Outside the trap case, `flag_fr` is 1 exactly when rounding incremented the kept fraction, and `flag_fi` equals the inexact flag.
- R10: The class code is taken from the binary32 form of the result:
  - quiet NaN 10001;
  - -inf 01001, -normal 01000, -denormal 11000, -zero 10010;
  - +zero 00010, +denormal 10100, +normal 00100, +inf 00101.
- R11: Zeros, infinities and values that are exact in binary32 pass through unchanged, with every status flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| src_data | input | 128 | Source word; the low 64 bits hold the binary64 operand |
| rnd_mode | input | 2 | Rounding direction select |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Registered result is valid |
| res_data | output | 128 | Result word: binary64 value low, zeros high |
| res_wr_en | output | 1 | Destination may be written |
| flag_snan | output | 1 | Signalling NaN operand |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow (tiny and inexact) |
| flag_inx | output | 1 | Inexact |
| flag_fr | output | 1 | Fraction was incremented |
| flag_fi | output | 1 | Fraction inexact |
| res_class | output | 5 | Result class code |

## Verification
The assertions assume that `in_valid` is low while reset is held, and that once a result is registered its flags only change together with a new accepted operand, so the relations between flags hold for held values as well. The bench drives every operand on the falling clock edge and keeps `in_valid` low during reset. It holds `in_valid` for one cycle per operation, so every flag pattern the checks see comes from a single rounding. The directed operands are chosen so that each checked relation is crossed from both sides:
- ties, carries into the exponent, and exact values;
- overflow at and just below 2^128;
- subnormal, sub-subnormal and NaN inputs, with the trap both on and off.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Format geometry
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_SIG_W  = SP_FRAC_W + 1;
    localparam int DROP_W    = DP_FRAC_W - SP_FRAC_W;     // 29 fraction bits dropped
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    localparam int REBIAS    = DP_BIAS - SP_BIAS;         // 896
    localparam int SP_EMIN   = 1 - SP_BIAS;               // -126
    localparam int SH_MAX    = DROP_W + SP_SIG_W + 29;    // 82: everything in sticky
    localparam int ALIGN_W   = DP_FRAC_W + 1 + SH_MAX;    // 135
    localparam int CLS_W     = 5;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_t;

    typedef struct packed {
        logic snan;
        logic ovf;
        logic unf;
        logic inx;
        logic fr;
    } flags_t;

    localparam logic [CLS_W-1:0] CLS_QNAN  = 5'b10001;
    localparam logic [CLS_W-1:0] CLS_NINF  = 5'b01001;
    localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;
    localparam logic [CLS_W-1:0] CLS_NDEN  = 5'b11000;
    localparam logic [CLS_W-1:0] CLS_NZERO = 5'b10010;
    localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
    localparam logic [CLS_W-1:0] CLS_PDEN  = 5'b10100;
    localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
    localparam logic [CLS_W-1:0] CLS_PINF  = 5'b00101;

    // Leading-zero count of a single-precision fraction field
    function automatic logic [4:0] lzc_frac(input logic [SP_FRAC_W-1:0] x);
        logic [4:0] n;
        logic       hit;
        n   = 5'd0;
        hit = 1'b0;
        for (int i = SP_FRAC_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (x[i]) hit = 1'b1;
                else      n   = n + 5'd1;
            end
        end
        return n;
    endfunction

    // Round-up decision from kept lsb, guard, sticky and sign
    function automatic logic round_up(input rmode_e rm, input logic sgn,
                                      input logic lsb, input logic g,
                                      input logic st);
        case (rm)
            RM_NEAR: return g & (st | lsb);
            RM_ZERO: return 1'b0;
            RM_UP:   return ~sgn & (g | st);
            default: return sgn & (g | st);
        endcase
    endfunction

endpackage

// File: rtl/dsr_round.sv
module dsr_round
    import dsr_pkg::*;
(
    input  logic [DP_W-1:0] din,
    input  logic [1:0]      rmode,
    output sp_t             res,
    output flags_t          flg
);

    logic                  s;
    logic [DP_EXP_W-1:0]   e;
    logic [DP_FRAC_W-1:0]  f;
    logic [DP_FRAC_W:0]    mant;
    logic signed [12:0]    eu;
    logic signed [12:0]    dn;
    logic signed [12:0]    ebw;
    logic [6:0]            sh;
    logic [ALIGN_W-30:0]   av;       // aligned window, bits 105..0
    logic [SP_SIG_W-1:0]   kept;
    logic                  gbit;
    logic                  sbit;
    logic                  inc;
    logic [SP_SIG_W:0]     sum;
    logic                  to_inf;
    rmode_e                rm;

    assign s  = din[DP_W-1];
    assign e  = din[DP_W-2 -: DP_EXP_W];
    assign f  = din[DP_FRAC_W-1:0];
    assign rm = rmode_e'(rmode);

    always_comb begin
        res    = '0;
        flg    = '0;
        mant   = '0;
        eu     = '0;
        dn     = '0;
        ebw    = '0;
        sh     = 7'(DROP_W);
        av     = '0;
        kept   = '0;
        gbit   = 1'b0;
        sbit   = 1'b0;
        inc    = 1'b0;
        sum    = '0;
        to_inf = 1'b0;

        if (e == '1) begin
            // NaN or infinity
            res.sign = s;
            res.exp  = '1;
            if (f != '0) begin
                res.frac = {1'b1, f[DP_FRAC_W-2 -: SP_FRAC_W-1]};
                flg.snan = ~f[DP_FRAC_W-1];
            end
        end else if (e == '0 && f == '0) begin
            res.sign = s;
        end else begin
            mant = {(e != '0), f};
            eu   = (e == '0) ? (13'sd1 - 13'(DP_BIAS))
                             : ($signed({2'b00, e}) - 13'(DP_BIAS));
            dn   = 13'(SP_EMIN) - eu;
            if (dn > 13'(SH_MAX - DROP_W))
                sh = 7'(SH_MAX);
            else if (dn > 13'sd0)
                sh = 7'(DROP_W) + 7'(dn);
            else
                sh = 7'(DROP_W);

            av   = (ALIGN_W-29)'({mant, {SH_MAX{1'b0}}} >> sh);
            kept = av[ALIGN_W-30 -: SP_SIG_W];
            gbit = av[SH_MAX-1];
            sbit = |av[SH_MAX-2:0];
            inc  = round_up(rm, s, kept[0], gbit, sbit);
            sum  = {1'b0, kept} + {{SP_SIG_W{1'b0}}, inc};

            flg.inx  = gbit | sbit;
            res.sign = s;

            if (dn > 13'sd0) begin
                // tiny operand: subnormal grid, may round up to min normal
                res.exp  = {{(SP_EXP_W-1){1'b0}}, sum[SP_FRAC_W]};
                res.frac = sum[SP_FRAC_W-1:0];
                flg.unf  = gbit | sbit;
                flg.fr   = inc;
            end else begin
                ebw = eu + 13'(SP_BIAS) + $signed({12'b0, sum[SP_SIG_W]});
                if (ebw >= 13'sd255) begin
                    to_inf  = (rm == RM_NEAR) | ((rm == RM_UP) & ~s)
                            | ((rm == RM_DOWN) & s);
                    flg.ovf = 1'b1;
                    flg.inx = 1'b1;
                    flg.fr  = 1'b0;
                    res.exp  = to_inf ? '1 : 8'hFE;
                    res.frac = to_inf ? '0 : '1;
                end else begin
                    res.exp  = ebw[SP_EXP_W-1:0];
                    res.frac = sum[SP_SIG_W] ? sum[SP_FRAC_W:1]
                                             : sum[SP_FRAC_W-1:0];
                    flg.fr   = inc;
                end
            end
        end
    end

endmodule

// File: rtl/dsr_widen.sv
module dsr_widen
    import dsr_pkg::*;
(
    input  sp_t             sp,
    output logic [DP_W-1:0] dp
);

    logic [4:0]           lz;
    logic [SP_FRAC_W-1:0] nfrac;

    assign lz = lzc_frac(sp.frac);

    always_comb begin
        nfrac = sp.frac << (lz + 5'd1);
        if (sp.exp == '1) begin
            dp = {sp.sign, {DP_EXP_W{1'b1}}, sp.frac, {DROP_W{1'b0}}};
        end else if (sp.exp == '0 && sp.frac == '0) begin
            dp = {sp.sign, {(DP_W-1){1'b0}}};
        end else if (sp.exp == '0) begin
            // renormalise a single subnormal into binary64
            dp = {sp.sign, 11'(11'(REBIAS) - {6'b0, lz}), nfrac, {DROP_W{1'b0}}};
        end else begin
            dp = {sp.sign, 11'({3'b000, sp.exp} + 11'(REBIAS)), sp.frac,
                  {DROP_W{1'b0}}};
        end
    end

endmodule

// File: rtl/dsr_classify.sv
module dsr_classify
    import dsr_pkg::*;
(
    input  sp_t              sp,
    output logic [CLS_W-1:0] cls
);

    always_comb begin
        if (sp.exp == '1)
            cls = (sp.frac != '0) ? CLS_QNAN : (sp.sign ? CLS_NINF : CLS_PINF);
        else if (sp.exp == '0 && sp.frac == '0)
            cls = sp.sign ? CLS_NZERO : CLS_PZERO;
        else if (sp.exp == '0)
            cls = sp.sign ? CLS_NDEN : CLS_PDEN;
        else
            cls = sp.sign ? CLS_NNORM : CLS_PNORM;
    end

endmodule

// File: rtl/dsr_unit.sv
module dsr_unit
    import dsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2*DP_W-1:0]  src_data,
    input  logic [1:0]         rnd_mode,
    input  logic               inv_trap_en,
    output logic               out_valid,
    output logic [2*DP_W-1:0]  res_data,
    output logic               res_wr_en,
    output logic               flag_snan,
    output logic               flag_ovf,
    output logic               flag_unf,
    output logic               flag_inx,
    output logic               flag_fr,
    output logic               flag_fi,
    output logic [CLS_W-1:0]   res_class
);

    sp_t              sp_res;
    flags_t           flg;
    logic [DP_W-1:0]  dp_res;
    logic [CLS_W-1:0] cls;
    logic             trap;
    logic             unused_upper;

    assign unused_upper = ^src_data[2*DP_W-1:DP_W];

    dsr_round u_round (
        .din   (src_data[DP_W-1:0]),
        .rmode (rnd_mode),
        .res   (sp_res),
        .flg   (flg)
    );

    dsr_widen u_widen (
        .sp (sp_res),
        .dp (dp_res)
    );

    dsr_classify u_class (
        .sp  (sp_res),
        .cls (cls)
    );

    assign trap = inv_trap_en & flg.snan;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_wr_en <= 1'b0;
            res_data  <= '0;
            flag_snan <= 1'b0;
            flag_ovf  <= 1'b0;
            flag_unf  <= 1'b0;
            flag_inx  <= 1'b0;
            flag_fr   <= 1'b0;
            flag_fi   <= 1'b0;
            res_class <= '0;
        end else begin
            out_valid <= in_valid;
            res_wr_en <= in_valid & ~trap;
            if (in_valid) begin
                res_data  <= {{DP_W{1'b0}}, dp_res};
                flag_snan <= flg.snan;
                flag_ovf  <= flg.ovf;
                flag_unf  <= flg.unf;
                flag_inx  <= flg.inx;
                flag_fr   <= trap ? 1'b0 : flg.fr;
                flag_fi   <= trap ? 1'b0 : flg.inx;
                res_class <= cls;
            end
        end
    end

    // R1
    valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_wr_en |-> out_valid);

    // R8
    trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !res_wr_en) |-> (flag_snan && !flag_fr && !flag_fi));

    // R9
    fr_needs_fi_chk: assert property (@(posedge clk) disable iff (rst)
        flag_fr |-> flag_fi);

    // R5
    ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        flag_ovf |-> (flag_inx && !flag_fr));

    // R6
    unf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        flag_unf |-> flag_inx);

endmodule

// File: tb/dsr_unit_tb_top.sv
module dsr_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] src_data;
    logic [1:0]   rnd_mode;
    logic         inv_trap_en;
    logic         out_valid;
    logic [127:0] res_data;
    logic         res_wr_en;
    logic         flag_snan, flag_ovf, flag_unf, flag_inx, flag_fr, flag_fi;
    logic [4:0]   res_class;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    localparam logic [1:0] NEAR = 2'b00, ZERO = 2'b01, UP = 2'b10, DOWN = 2'b11;
    localparam logic [63:0] JUNK = 64'hA5A5_5A5A_DEAD_BEEF;

    always #10 clk = ~clk;   // 50 MHz

    dsr_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_data(src_data),
        .rnd_mode(rnd_mode), .inv_trap_en(inv_trap_en), .out_valid(out_valid),
        .res_data(res_data), .res_wr_en(res_wr_en), .flag_snan(flag_snan),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx),
        .flag_fr(flag_fr), .flag_fi(flag_fi), .res_class(res_class)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // flags expected as {snan, ovf, unf, inx, fr, fi}
    task automatic run_case(input string req, input logic [63:0] op,
                            input logic [1:0] rm, input logic trap_en,
                            input logic [63:0] exp_dp, input logic [5:0] exp_fl,
                            input logic exp_wr, input logic [4:0] exp_cls);
        @(negedge clk);
        in_valid    = 1'b1;
        src_data    = {JUNK, op};
        rnd_mode    = rm;
        inv_trap_en = trap_en;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "value", {64'b0, res_data[63:0]}, {64'b0, exp_dp});
        chk("R2", "upper half", {64'b0, res_data[127:64]}, 128'b0);
        chk(req, "flags snan/ovf/unf/inx",
            {124'b0, flag_snan, flag_ovf, flag_unf, flag_inx},
            {124'b0, exp_fl[5:2]});
        chk("R9", "fr/fi", {126'b0, flag_fr, flag_fi}, {126'b0, exp_fl[1:0]});
        chk("R8", "write enable", {127'b0, res_wr_en}, {127'b0, exp_wr});
        chk("R10", "class", {123'b0, res_class}, {123'b0, exp_cls});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; src_data = '0; rnd_mode = NEAR;
        inv_trap_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset out_valid", {127'b0, out_valid}, 128'b0);
        chk("R1", "reset wr_en", {127'b0, res_wr_en}, 128'b0);
        chk("R1", "reset flags", {122'b0, flag_snan, flag_ovf, flag_unf,
            flag_inx, flag_fr, flag_fi}, 128'b0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_latency;
        @(negedge clk);
        in_valid = 1'b1; src_data = {JUNK, 64'h3FF0_0000_0000_0000};
        rnd_mode = NEAR; inv_trap_en = 1'b0;
        @(posedge clk); #1;
        chk("R1", "valid one cycle later", {127'b0, out_valid}, {127'b0, 1'b1});
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1", "valid drops", {127'b0, out_valid}, 128'b0);
    endtask

    task automatic t_exact;
        run_case("R11", 64'h3FF0_0000_0000_0000, NEAR, 0, 64'h3FF0_0000_0000_0000, 6'b000000, 1, 5'b00100);
        run_case("R11", 64'h8000_0000_0000_0000, UP,   0, 64'h8000_0000_0000_0000, 6'b000000, 1, 5'b10010);
        run_case("R11", 64'hFFF0_0000_0000_0000, NEAR, 0, 64'hFFF0_0000_0000_0000, 6'b000000, 1, 5'b01001);
        run_case("R11", 64'h7FF0_0000_0000_0000, DOWN, 0, 64'h7FF0_0000_0000_0000, 6'b000000, 1, 5'b00101);
        run_case("R11", 64'h0000_0000_0000_0000, NEAR, 0, 64'h0000_0000_0000_0000, 6'b000000, 1, 5'b00010);
    endtask

    task automatic t_modes;
        run_case("R4", 64'h3FF0_0000_1000_0000, NEAR, 0, 64'h3FF0_0000_0000_0000, 6'b000101, 1, 5'b00100);
        run_case("R4", 64'h3FF0_0000_3000_0000, NEAR, 0, 64'h3FF0_0000_4000_0000, 6'b000111, 1, 5'b00100);
        run_case("R3", 64'h3FF0_0000_1000_0000, UP,   0, 64'h3FF0_0000_2000_0000, 6'b000111, 1, 5'b00100);
        run_case("R3", 64'h3FF0_0000_1000_0000, ZERO, 0, 64'h3FF0_0000_0000_0000, 6'b000101, 1, 5'b00100);
        run_case("R3", 64'hBFF0_0000_1000_0000, DOWN, 0, 64'hBFF0_0000_2000_0000, 6'b000111, 1, 5'b01000);
        run_case("R3", 64'hBFF0_0000_1000_0000, UP,   0, 64'hBFF0_0000_0000_0000, 6'b000101, 1, 5'b01000);
        run_case("R3", 64'h3FFF_FFFF_FFFF_FFFF, NEAR, 0, 64'h4000_0000_0000_0000, 6'b000111, 1, 5'b00100);
    endtask

    task automatic t_overflow;
        run_case("R5", 64'h47F0_0000_0000_0000, NEAR, 0, 64'h7FF0_0000_0000_0000, 6'b010101, 1, 5'b00101);
        run_case("R5", 64'h47EF_FFFF_FFFF_FFFF, NEAR, 0, 64'h7FF0_0000_0000_0000, 6'b010101, 1, 5'b00101);
        run_case("R5", 64'h47EF_FFFF_FFFF_FFFF, ZERO, 0, 64'h47EF_FFFF_E000_0000, 6'b000101, 1, 5'b00100);
        run_case("R5", 64'h47F0_0000_0000_0000, ZERO, 0, 64'h47EF_FFFF_E000_0000, 6'b010101, 1, 5'b00100);
        run_case("R5", 64'hC7F0_0000_0000_0000, UP,   0, 64'hC7EF_FFFF_E000_0000, 6'b010101, 1, 5'b01000);
        run_case("R5", 64'hC7F0_0000_0000_0000, DOWN, 0, 64'hFFF0_0000_0000_0000, 6'b010101, 1, 5'b01001);
    endtask

    task automatic t_tiny;
        run_case("R6", 64'h36A0_0000_0000_0000, NEAR, 0, 64'h36A0_0000_0000_0000, 6'b000000, 1, 5'b10100);
        run_case("R6", 64'h36B8_0000_0000_0000, ZERO, 0, 64'h36B8_0000_0000_0000, 6'b000000, 1, 5'b10100);
        run_case("R6", 64'h3690_0000_0000_0000, NEAR, 0, 64'h0000_0000_0000_0000, 6'b001101, 1, 5'b00010);
        run_case("R6", 64'h3690_0000_0000_0000, UP,   0, 64'h36A0_0000_0000_0000, 6'b001111, 1, 5'b10100);
        run_case("R6", 64'h8000_0000_0000_0001, DOWN, 0, 64'hB6A0_0000_0000_0000, 6'b001111, 1, 5'b11000);
        run_case("R6", 64'h380F_FFFF_FFFF_FFFF, NEAR, 0, 64'h3810_0000_0000_0000, 6'b001111, 1, 5'b00100);
    endtask

    task automatic t_nan;
        run_case("R7", 64'h7FF0_0000_0000_0001, NEAR, 0, 64'h7FF8_0000_0000_0000, 6'b100000, 1, 5'b10001);
        run_case("R7", 64'h7FF4_0000_1234_5678, ZERO, 0, 64'h7FFC_0000_0000_0000, 6'b100000, 1, 5'b10001);
        run_case("R7", 64'hFFF8_0000_0000_0000, NEAR, 1, 64'hFFF8_0000_0000_0000, 6'b000000, 1, 5'b10001);
    endtask

    task automatic t_trap;
        run_case("R8", 64'h7FF4_0000_1234_5678, NEAR, 1, 64'h7FFC_0000_0000_0000, 6'b100000, 0, 5'b10001);
        run_case("R8", 64'h3FF0_0000_1000_0000, UP,   1, 64'h3FF0_0000_2000_0000, 6'b000111, 1, 5'b00100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_exact();
        t_modes();
        t_overflow();
        t_tiny();
        t_nan();
        t_trap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule